// File: doc/BRIEF.md
# Highway and Farm Road Signal Controller

This block runs the lamps at a crossing where a busy highway meets a farm road that carries little traffic. The highway shows green by default. A sensor on the farm road tells the block when a vehicle is waiting. The highway gives way only after it has held green for a guaranteed minimum time. It then shows amber for a short interval, and the farm road turns green.

The farm road keeps its green while a vehicle is still sensed, up to the long interval at most. It then shows amber for the short interval, and the highway turns green again. A built-in interval counter measures both periods, and its lengths are parameters. Every change of phase restarts the counter through a single-cycle restart strobe, which is also brought out as a port. A parameter chooses a binary or a one-hot phase register. The two choices behave the same at the ports.

Top module: `road_signal_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block enters the highway-green phase, whatever `car_present` is. The highway lamp is then green (3'b100), the farm lamp is red (3'b001), and `timer_restart` is low in the cycle after that edge.
- R2: The highway-green phase is kept in every cycle unless the long interval has expired and `car_present` is high. Each highway-green phase that ends in amber has lasted at least LONG_CYCLES+1 clock cycles.
- R3: In highway green, in a cycle where the long interval has expired (LONG_CYCLES cycles since entry) and `car_present` is high, `timer_restart` is high, and the next phase is highway amber (3'b010) with the farm lamp red.
- R4: Highway amber lasts exactly SHORT_CYCLES+1 cycles and is followed by farm green: farm lamp 3'b100, highway lamp 3'b001.
- R5: Farm green ends after any cycle in which `car_present` is low or the long interval has expired. It therefore lasts at most LONG_CYCLES+1 cycles, and exactly one cycle if no vehicle is sensed on entry. It is followed by farm amber: farm lamp 3'b010, highway lamp 3'b001.
- R6: Farm amber lasts exactly SHORT_CYCLES+1 cycles and is followed by highway green.
- R7: Lamp encoding is bit 0 red, bit 1 amber, bit 2 green. Each road has exactly one lamp lit in every cycle, and at least one of the two roads shows red.
- R8: `timer_restart` is high in exactly the cycles after which the phase changes at the next clock edge. The interval count starts again from zero in the first cycle of each new phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| car_present | input | 1 | Vehicle sensed waiting on the farm road |
| hwy_lamp | output | 3 | Highway lamps, one-hot {green, amber, red} |
| farm_lamp | output | 3 | Farm road lamps, one-hot {green, amber, red} |
| timer_restart | output | 1 | One-cycle strobe marking a phase change and restarting the interval count |

## Verification
The hardest case to reach from the ports is the boundary between the two ways farm green can end. One is a vehicle leaving in exactly the cycle the long interval expires. The other is a vehicle that is already gone when farm green begins, which leaves a one-cycle green and two restart strobes back to back. The stimulus reaches these through a directed run in which the sensor drops the moment farm green appears, and through random blocks whose sensor activity switches between sparse, dense, steady and toggling every cycle. A reset applied during a farm phase checks the return to highway green from the middle of the cycle.

// File: rtl/road_signal_pkg.sv
package road_signal_pkg;

   typedef enum logic [1:0] {
      PH_HWY_GO    = 2'd0,
      PH_HWY_WARN  = 2'd1,
      PH_FARM_GO   = 2'd2,
      PH_FARM_WARN = 2'd3
   } phase_t;

   localparam int LAMP_W = 3;
   localparam int PHASE_N = 4;

   localparam logic [LAMP_W-1:0] LAMP_RED   = 3'b001;
   localparam logic [LAMP_W-1:0] LAMP_AMBER = 3'b010;
   localparam logic [LAMP_W-1:0] LAMP_GREEN = 3'b100;

endpackage

// File: rtl/road_interval_timer.sv
module road_interval_timer #(
   parameter int SHORT_CYCLES = 4,
   parameter int LONG_CYCLES  = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic short_done,
   output logic long_done
);
   localparam int CNT_W = $clog2(LONG_CYCLES + 1);
   localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_CYCLES);
   localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_CYCLES);

   if (SHORT_CYCLES < 1) begin : g_bad_short
      $error("road_interval_timer: SHORT_CYCLES must be at least 1");
   end
   if (LONG_CYCLES <= SHORT_CYCLES) begin : g_bad_long
      $error("road_interval_timer: LONG_CYCLES must exceed SHORT_CYCLES");
   end

   logic [CNT_W-1:0] count_q;

   // count saturates at the long limit so both flags stay high
   always_ff @(posedge clk) begin
      if (rst || restart) begin
         count_q <= '0;
      end else if (count_q != LONG_LIM) begin
         count_q <= count_q + 1'b1;
      end
   end

   assign short_done = (count_q >= SHORT_LIM);
   assign long_done  = (count_q == LONG_LIM);

endmodule

// File: rtl/road_phase_seq.sv
module road_phase_seq
   import road_signal_pkg::*;
#(
   parameter bit ONEHOT_STATE = 1'b0
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   car_present,
   input  logic   short_done,
   input  logic   long_done,
   output phase_t phase,
   output logic   restart
);
   phase_t phase_nxt;

   // exit conditions per phase; restart marks every exit
   always_comb begin
      phase_nxt = phase;
      restart   = 1'b0;
      unique case (phase)
         PH_HWY_GO: begin
            if (long_done && car_present) begin
               phase_nxt = PH_HWY_WARN;
               restart   = 1'b1;
            end
         end
         PH_HWY_WARN: begin
            if (short_done) begin
               phase_nxt = PH_FARM_GO;
               restart   = 1'b1;
            end
         end
         PH_FARM_GO: begin
            if (long_done || !car_present) begin
               phase_nxt = PH_FARM_WARN;
               restart   = 1'b1;
            end
         end
         PH_FARM_WARN: begin
            if (short_done) begin
               phase_nxt = PH_HWY_GO;
               restart   = 1'b1;
            end
         end
         default: begin
            phase_nxt = PH_HWY_GO;
            restart   = 1'b1;
         end
      endcase
   end

   if (ONEHOT_STATE) begin : g_onehot
      logic [PHASE_N-1:0] hot_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            hot_q <= PHASE_N'(1);
         end else begin
            hot_q <= PHASE_N'(1) << phase_nxt;
         end
      end

      always_comb begin
         phase = PH_HWY_GO;
         if (hot_q[1]) phase = PH_HWY_WARN;
         if (hot_q[2]) phase = PH_FARM_GO;
         if (hot_q[3]) phase = PH_FARM_WARN;
      end
   end else begin : g_binary
      always_ff @(posedge clk) begin
         if (rst) begin
            phase <= PH_HWY_GO;
         end else begin
            phase <= phase_nxt;
         end
      end
   end

endmodule

// File: rtl/road_lamp_decode.sv
module road_lamp_decode
   import road_signal_pkg::*;
(
   input  phase_t            phase,
   output logic [LAMP_W-1:0] hwy_lamp,
   output logic [LAMP_W-1:0] farm_lamp
);
   always_comb begin
      hwy_lamp  = LAMP_RED;
      farm_lamp = LAMP_RED;
      unique case (phase)
         PH_HWY_GO:    hwy_lamp  = LAMP_GREEN;
         PH_HWY_WARN:  hwy_lamp  = LAMP_AMBER;
         PH_FARM_GO:   farm_lamp = LAMP_GREEN;
         PH_FARM_WARN: farm_lamp = LAMP_AMBER;
         default:      hwy_lamp  = LAMP_RED;
      endcase
   end

endmodule

// File: rtl/road_signal_ctrl.sv
module road_signal_ctrl
   import road_signal_pkg::*;
#(
   parameter int SHORT_CYCLES = 4,
   parameter int LONG_CYCLES  = 12,
   parameter bit ONEHOT_STATE = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       car_present,
   output logic [2:0] hwy_lamp,
   output logic [2:0] farm_lamp,
   output logic       timer_restart
);
   logic   tmr_short;
   logic   tmr_long;
   phase_t cur_phase;

   road_interval_timer #(
      .SHORT_CYCLES (SHORT_CYCLES),
      .LONG_CYCLES  (LONG_CYCLES)
   ) timer_i (
      .clk        (clk),
      .rst        (rst),
      .restart    (timer_restart),
      .short_done (tmr_short),
      .long_done  (tmr_long)
   );

   road_phase_seq #(
      .ONEHOT_STATE (ONEHOT_STATE)
   ) seq_i (
      .clk         (clk),
      .rst         (rst),
      .car_present (car_present),
      .short_done  (tmr_short),
      .long_done   (tmr_long),
      .phase       (cur_phase),
      .restart     (timer_restart)
   );

   road_lamp_decode lamp_i (
      .phase     (cur_phase),
      .hwy_lamp  (hwy_lamp),
      .farm_lamp (farm_lamp)
   );

endmodule

// File: rtl/road_signal_ctrl_chk.sv
module road_signal_ctrl_chk (
   input logic       clk,
   input logic       rst,
   input logic       car_present,
   input logic [2:0] hwy_lamp,
   input logic [2:0] farm_lamp,
   input logic       timer_restart,
   input logic       tmr_short,
   input logic       tmr_long
);
   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (hwy_lamp == 3'b100 && farm_lamp == 3'b001));

   // R7
   lamp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones(hwy_lamp) == 1 && $countones(farm_lamp) == 1));

   // R7
   one_red_chk: assert property (@(posedge clk) disable iff (rst)
      (hwy_lamp[0] || farm_lamp[0]));

   // R2
   hwy_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (hwy_lamp == 3'b100 && !(tmr_long && car_present)) |=> hwy_lamp == 3'b100);

   // R3
   hwy_leave_chk: assert property (@(posedge clk) disable iff (rst)
      (hwy_lamp == 3'b100 && tmr_long && car_present) |=> hwy_lamp == 3'b010);

   // R3
   hwy_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      (hwy_lamp == 3'b100 && tmr_long && car_present) |-> timer_restart);

   // R4
   amber_to_farm_chk: assert property (@(posedge clk) disable iff (rst)
      (hwy_lamp == 3'b010 && tmr_short) |=> farm_lamp == 3'b100);

   // R5
   farm_leave_chk: assert property (@(posedge clk) disable iff (rst)
      (farm_lamp == 3'b100 && (tmr_long || !car_present)) |=> farm_lamp == 3'b010);

   // R6
   farm_amber_end_chk: assert property (@(posedge clk) disable iff (rst)
      (farm_lamp == 3'b010 && tmr_short) |=> hwy_lamp == 3'b100);

   // R8
   strobe_moves_chk: assert property (@(posedge clk) disable iff (rst)
      timer_restart |=> !$stable({hwy_lamp, farm_lamp}));

   // R8
   no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !timer_restart |=> $stable({hwy_lamp, farm_lamp}));

   // R8
   count_clear_chk: assert property (@(posedge clk) disable iff (rst)
      timer_restart |=> (!tmr_short && !tmr_long));

endmodule

bind road_signal_ctrl road_signal_ctrl_chk chk_i (
   .clk           (clk),
   .rst           (rst),
   .car_present   (car_present),
   .hwy_lamp      (hwy_lamp),
   .farm_lamp     (farm_lamp),
   .timer_restart (timer_restart),
   .tmr_short     (tmr_short),
   .tmr_long      (tmr_long)
);

// File: tb/road_signal_ctrl_test.sv
`timescale 1ns/1ps
module road_signal_ctrl_test;
   localparam int SHORT = 4;
   localparam int LONG  = 12;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       car = 1'b0;
   logic [2:0] hwy_lamp;
   logic [2:0] farm_lamp;
   logic       timer_restart;

   int  checks = 0;
   int  errors = 0;
   int  ph = 0;
   int  dwell = 0;
   int  hg_run = 0;
   bit  finished = 1'b0;
   int unsigned seed_v;

   always #2.5 clk = ~clk;

   road_signal_ctrl #(
      .SHORT_CYCLES (SHORT),
      .LONG_CYCLES  (LONG),
      .ONEHOT_STATE (1'b0)
   ) uut (
      .clk           (clk),
      .rst           (rst),
      .car_present   (car),
      .hwy_lamp      (hwy_lamp),
      .farm_lamp     (farm_lamp),
      .timer_restart (timer_restart)
   );

   function automatic logic [2:0] exp_hwy(int p);
      case (p)
         0: return 3'b100;
         1: return 3'b010;
         default: return 3'b001;
      endcase
   endfunction

   function automatic logic [2:0] exp_farm(int p);
      case (p)
         2: return 3'b100;
         3: return 3'b010;
         default: return 3'b001;
      endcase
   endfunction

   function automatic bit exp_go(int p, int d, bit c);
      case (p)
         0: return (d >= LONG) && c;
         1: return d >= SHORT;
         2: return (d >= LONG) || !c;
         default: return d >= SHORT;
      endcase
   endfunction

   function automatic string phase_req(int p);
      case (p)
         0: return "R2";
         1: return "R4";
         2: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called just after a falling edge; leaves just after the next one
   task automatic step(input bit c);
      bit go;
      car = c;
      #1;
      go = exp_go(ph, dwell, c);
      check(phase_req(ph), {29'd0, hwy_lamp}, {29'd0, exp_hwy(ph)});
      check(phase_req(ph), {29'd0, farm_lamp}, {29'd0, exp_farm(ph)});
      check((ph == 0) ? "R3" : "R8", {31'd0, timer_restart}, {31'd0, go});
      check("R7", {29'd0, ($countones(hwy_lamp) == 1), ($countones(farm_lamp) == 1),
                   (hwy_lamp == 3'b001 || farm_lamp == 3'b001)}, 32'd7);
      if (hwy_lamp == 3'b100) begin
         hg_run++;
      end else if (hg_run > 0) begin
         // R2 minimum highway green
         check("R2", {31'd0, (hg_run >= LONG + 1)}, 32'd1);
         hg_run = 0;
      end
      if (go) begin
         ph    = (ph + 1) % 4;
         dwell = 0;
      end else if (dwell < LONG) begin
         dwell++;
      end
      @(negedge clk);
   endtask

   task automatic do_reset(input bit c);
      rst = 1'b1;
      car = c;
      @(negedge clk);
      #1;
      // R1 state right after a reset edge, sensor value irrelevant
      check("R1", {29'd0, hwy_lamp}, 32'h4);
      check("R1", {29'd0, farm_lamp}, 32'h1);
      check("R1", {31'd0, timer_restart}, 32'd0);
      rst    = 1'b0;
      ph     = 0;
      dwell  = 0;
      hg_run = 0;
   endtask

   initial begin
      seed_v = $urandom(32'd4242);
      @(negedge clk);
      do_reset(1'b1);

      // R2: no vehicle, highway stays green well past the long interval
      for (int i = 0; i < 3 * LONG; i++) step(1'b0);

      // R3 R4 R5 R6: steady vehicle, full cycle with farm green capped
      for (int i = 0; i < 4 * (LONG + SHORT + 2); i++) step(1'b1);

      // R5: vehicle leaves the moment farm green shows, one-cycle green
      while (ph != 2) step(1'b1);
      step(1'b0);
      for (int i = 0; i < 2 * LONG; i++) step(1'b0);

      // R1: reset in the middle of a farm phase
      while (ph != 2) step(1'b1);
      step(1'b1);
      do_reset(1'b0);
      for (int i = 0; i < LONG + 4; i++) step(1'b1);

      // random blocks with varying sensor activity
      for (int blk = 0; blk < 30; blk++) begin
         int mode;
         mode = $urandom_range(0, 3);
         for (int i = 0; i < 100; i++) begin
            bit c;
            case (mode)
               0: c = ($urandom_range(0, 9) == 0);
               1: c = $urandom_range(0, 1) != 0;
               2: c = ($urandom_range(0, 9) != 0);
               default: c = i[0];
            endcase
            step(c);
         end
         if (blk % 10 == 9) do_reset($urandom_range(0, 1) != 0);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule